// File: doc/BRIEF.md
# Instruction-Driven DMA Request Frontend

This block sits on a processor's accelerator offload port and turns decoded custom DMA instructions into DMA job descriptors. The instructions that set the source address, the destination address, the 2D strides, the repetition count and the bus user field write shadow registers inside the block. A copy instruction builds a descriptor from those registers, its length operand and its config field. It pushes the descriptor into the request FIFO of the selected channel and returns a per-channel transfer ID. A status instruction reads one of four per-channel values. Copy and status instructions answer through a response port that carries the destination register tag.

Each channel has its own request FIFO and its own pair of ID counters. The transfer engine behind a FIFO pops descriptors through a valid/ready pair and pulses a done input as each transfer retires. When a copy targets a full FIFO, the instruction port is stalled and no request is lost.

Top module: `dma_insn_frontend`

## Requirements
- R1: Opcode 0 sets the source address and opcode 1 sets the destination address. Bits [31:0] come from rs1 and bits [AW-1:32] come from the low bits of rs2. Both registers reset to zero.
- R2: Opcode 2 loads the source stride from rs1 and the destination stride from rs2. Opcode 3 loads the repetition count from rs1. All three reset to zero and keep their values across launches.
- R3: Opcode 4 loads the user field. When UW is 32 or less it is rs1[UW-1:0]. Otherwise it is {rs2[UW-33:0], rs1}.
- R4: An accepted copy (opcode 5 or 6) pushes a descriptor packed from MSB to LSB as {src, dst, length=rs1, src_stride, dst_stride, reps, user}. The descriptor is visible at that channel's FIFO output from the next cycle when the FIFO was empty.
- R5: Opcodes 5 (copy) and 7 (status) take their config from imm[4:0]. Opcodes 6 (copy) and 8 (status) take it from rs2[4:0]. Bit 0 is ignored. Bit 1 enables 2D. The channel is bits [2 +: clog2(NCH)], and any higher bits are ignored.
- R6: A copy with bit 1 clear pushes zero strides and a repetition count of 1, whatever the shadow registers hold.
- R7: A copy returns the channel's next transfer ID on the response port one cycle after acceptance, tagged with its rd. Each channel's IDs start at 1 after reset and rise by one per launch.
- R8: For a status query, config bits [1:0] select the value returned one cycle after acceptance: 0 gives the completed count (starts at 0, +1 per done pulse), 1 gives the next ID, 2 gives busy (issued not equal to completed), and 3 gives FIFO full. Values are zero-extended to 64 bits.
- R9: While a valid copy targets a full FIFO, instr_ready is low. The copy is accepted once space frees, and no descriptor is dropped.
- R10: Opcodes 0 to 4 produce no response.
- R11: Each FIFO delivers in arrival order and holds its output stable while it is not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Instruction accepted this cycle when valid |
| instr_op | input | 4 | Decoded opcode, 0 to 8 |
| instr_rd | input | 5 | Destination register tag |
| instr_rs1 | input | 32 | First register operand |
| instr_rs2 | input | 32 | Second register operand |
| instr_imm | input | 12 | Immediate operand |
| rsp_valid | output | 1 | Response write strobe |
| rsp_rd | output | 5 | Response register tag |
| rsp_data | output | 64 | Transfer ID or status value |
| req_valid | output | NCH | Per-channel FIFO not empty |
| req_ready | input | NCH | Per-channel pop |
| req_data | output | NCH*(2*AW+128+UW) | Per-channel FIFO head descriptor |
| xfer_done | input | NCH | Per-channel retire pulse |

## Verification
The bench builds the block with two channels, a FIFO depth of two, a 48-bit address and a 40-bit user field. With a depth of two, FIFO-full stalls and full-flag queries are reached after only a few launches. Two channels allow the channel field to be tested, including its ignored upper bit and the separate ID sequences. A user width above 32 exercises the path that splits the field across rs1 and rs2.

// File: rtl/dma_insn_frontend.sv
module dma_insn_frontend #(
  parameter int AW    = 48,
  parameter int UW    = 40,
  parameter int NCH   = 2,
  parameter int DEPTH = 2,
  parameter int IDW   = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            instr_valid,
  output logic                            instr_ready,
  input  logic [3:0]                      instr_op,
  input  logic [4:0]                      instr_rd,
  input  logic [31:0]                     instr_rs1,
  input  logic [31:0]                     instr_rs2,
  input  logic [11:0]                     instr_imm,
  output logic                            rsp_valid,
  output logic [4:0]                      rsp_rd,
  output logic [63:0]                     rsp_data,
  output logic [NCH-1:0]                  req_valid,
  input  logic [NCH-1:0]                  req_ready,
  output logic [NCH*(2*AW+128+UW)-1:0]    req_data,
  input  logic [NCH-1:0]                  xfer_done
);
  localparam int RW  = 2*AW + 128 + UW;
  localparam int CHW = NCH > 1 ? $clog2(NCH) : 1;
  localparam int PW  = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);

  localparam logic [3:0] OP_SRC = 4'd0, OP_DST = 4'd1, OP_STR = 4'd2, OP_REP = 4'd3,
                         OP_USR = 4'd4, OP_CPI = 4'd5, OP_CPR = 4'd6, OP_STI = 4'd7,
                         OP_STR2 = 4'd8;

  logic [AW-1:0]  src_q, dst_q;
  logic [31:0]    sstr_q, dstr_q, reps_q;
  logic [UW-1:0]  user_q, user_in;
  logic [4:0]     cfg;
  logic [CHW-1:0] ch;
  logic           is_copy, is_stat, fire, two_d;
  logic [NCH-1:0] full;
  logic [NCH*IDW-1:0] nid_flat, did_flat;
  logic [IDW-1:0] nid_sel, did_sel;
  logic [RW-1:0]  desc;
  logic [63:0]    stat_val;

  assign is_copy = (instr_op == OP_CPI) || (instr_op == OP_CPR);
  assign is_stat = (instr_op == OP_STI) || (instr_op == OP_STR2);
  assign cfg     = (instr_op == OP_CPR || instr_op == OP_STR2) ? instr_rs2[4:0] : instr_imm[4:0];
  assign ch      = NCH > 1 ? cfg[2 +: CHW] : '0;
  assign two_d   = cfg[1];
  assign instr_ready = !(instr_valid && is_copy && full[ch]);
  assign fire    = instr_valid && instr_ready;

  generate
    if (UW <= 32) begin : g_user_narrow
      assign user_in = instr_rs1[UW-1:0];
    end else begin : g_user_wide
      assign user_in = {instr_rs2[UW-33:0], instr_rs1};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; sstr_q <= '0; dstr_q <= '0; reps_q <= '0; user_q <= '0;
    end else if (fire) begin
      case (instr_op)
        OP_SRC: src_q <= {instr_rs2[AW-33:0], instr_rs1};
        OP_DST: dst_q <= {instr_rs2[AW-33:0], instr_rs1};
        OP_STR: begin sstr_q <= instr_rs1; dstr_q <= instr_rs2; end
        OP_REP: reps_q <= instr_rs1;
        OP_USR: user_q <= user_in;
        default: ;
      endcase
    end
  end

  assign desc = {src_q, dst_q, instr_rs1,
                 two_d ? sstr_q : 32'd0, two_d ? dstr_q : 32'd0, two_d ? reps_q : 32'd1,
                 user_q};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [RW-1:0]  mem [DEPTH];
      logic [PW-1:0]  wp, rp;
      logic [CW-1:0]  cnt;
      logic [IDW-1:0] nid, did;
      logic           push, pop;

      assign push = fire && is_copy && (ch == CHW'(c));
      assign pop  = req_valid[c] && req_ready[c];
      assign full[c]      = (cnt == CW'(DEPTH));
      assign req_valid[c] = (cnt != '0);
      assign req_data[c*RW +: RW] = mem[rp];
      assign nid_flat[c*IDW +: IDW] = nid;
      assign did_flat[c*IDW +: IDW] = did;

      always_ff @(posedge clk)
        if (push) mem[wp] <= desc;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wp <= '0; rp <= '0; cnt <= '0; nid <= IDW'(1); did <= '0;
        end else begin
          if (push) begin
            wp  <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            nid <= nid + 1'b1;
          end
          if (pop) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
          if (push && !pop) cnt <= cnt + 1'b1;
          else if (pop && !push) cnt <= cnt - 1'b1;
          if (xfer_done[c]) did <= did + 1'b1;
        end
      end
    end
  endgenerate

  assign nid_sel = nid_flat[ch*IDW +: IDW];
  assign did_sel = did_flat[ch*IDW +: IDW];

  always_comb begin
    case (cfg[1:0])
      2'd0:    stat_val = 64'(did_sel);
      2'd1:    stat_val = 64'(nid_sel);
      2'd2:    stat_val = 64'(nid_sel != did_sel + 1'b1);
      default: stat_val = 64'(full[ch]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_rd <= '0; rsp_data <= '0;
    end else begin
      rsp_valid <= fire && (is_copy || is_stat);
      if (fire && (is_copy || is_stat)) begin
        rsp_rd   <= instr_rd;
        rsp_data <= is_copy ? 64'(nid_sel) : stat_val;
      end
    end
  end
endmodule

// File: rtl/dma_insn_frontend_chk.sv
module dma_insn_frontend_chk #(
  parameter int AW  = 48,
  parameter int UW  = 40,
  parameter int NCH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         instr_valid,
  input logic                         instr_ready,
  input logic [3:0]                   instr_op,
  input logic                         rsp_valid,
  input logic [NCH-1:0]               req_valid,
  input logic [NCH-1:0]               req_ready,
  input logic [NCH*(2*AW+128+UW)-1:0] req_data
);
  localparam int RW = 2*AW + 128 + UW;
  logic cp, rq;
  assign cp = instr_op == 4'd5 || instr_op == 4'd6;
  assign rq = cp || instr_op == 4'd7 || instr_op == 4'd8;

  assert_stall_only_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ready |-> (instr_valid && cp));

  assert_rsp_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(instr_valid && instr_ready && rq));

  assert_query_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && rq) |=> rsp_valid);

  assert_push_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && cp) |=> (|req_valid));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_hold
      assert_head_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[c] && !req_ready[c]) |=> (req_valid[c] && $stable(req_data[c*RW +: RW])));
    end
  endgenerate
endmodule

bind dma_insn_frontend dma_insn_frontend_chk #(.AW(AW), .UW(UW), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr_op(instr_op), .rsp_valid(rsp_valid), .req_valid(req_valid),
  .req_ready(req_ready), .req_data(req_data));

// File: tb/dma_insn_frontend_tb_top.sv
`timescale 1ns/1ps
module dma_insn_frontend_tb_top;
  localparam int AW = 48, UW = 40, NCH = 2, DEPTH = 2;
  localparam int RW = 2*AW + 128 + UW;

  typedef struct packed {
    logic [3:0]  op;
    logic [4:0]  rd;
    logic [31:0] rs1;
    logic [31:0] rs2;
    logic [11:0] imm;
    logic        ev;
    logic [63:0] ed;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{4'd7, 5'd3,  32'h0,         32'h0,     12'h001, 1'b1, 64'd1},  // R8 next id
    '{4'd7, 5'd3,  32'h0,         32'h0,     12'h000, 1'b1, 64'd0},  // R8 completed
    '{4'd7, 5'd3,  32'h0,         32'h0,     12'h002, 1'b1, 64'd0},  // R8 busy
    '{4'd0, 5'd1,  32'h1000_0000, 32'hABCD,  12'h000, 1'b0, 64'd0},  // R1 R10
    '{4'd1, 5'd1,  32'h2000_0000, 32'h1234,  12'h000, 1'b0, 64'd0},  // R1 R10
    '{4'd2, 5'd1,  32'h10,        32'h20,    12'h000, 1'b0, 64'd0},  // R2 R10
    '{4'd3, 5'd1,  32'h5,         32'h0,     12'h000, 1'b0, 64'd0},  // R2 R10
    '{4'd4, 5'd1,  32'hDEAD_BEEF, 32'h77,    12'h000, 1'b0, 64'd0},  // R3 R10
    '{4'd5, 5'd5,  32'h40,        32'h0,     12'h002, 1'b1, 64'd1},  // R7 2D ch0
    '{4'd6, 5'd6,  32'h80,        32'h0,     12'h000, 1'b1, 64'd2},  // R7 1D ch0
    '{4'd7, 5'd4,  32'h0,         32'h0,     12'h003, 1'b1, 64'd1},  // R8 full
    '{4'd7, 5'd4,  32'h0,         32'h0,     12'h001, 1'b1, 64'd3},  // R8 next
    '{4'd7, 5'd4,  32'h0,         32'h0,     12'h002, 1'b1, 64'd1},  // R8 busy
    '{4'd5, 5'd7,  32'h300,       32'h0,     12'h00C, 1'b1, 64'd1},  // R5 ch1, bit3 ignored
    '{4'd8, 5'd8,  32'h0,         32'h5,     12'h000, 1'b1, 64'd2},  // R5 rs2 cfg, ch1 next
    '{4'd8, 5'd8,  32'h0,         32'h3,     12'h000, 1'b1, 64'd1}   // R8 ch0 full
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0, instr_ready;
  logic [3:0] instr_op = '0;
  logic [4:0] instr_rd = '0;
  logic [31:0] instr_rs1 = '0, instr_rs2 = '0;
  logic [11:0] instr_imm = '0;
  logic rsp_valid;
  logic [4:0] rsp_rd;
  logic [63:0] rsp_data;
  logic [NCH-1:0] req_valid, req_ready = '0, xfer_done = '0;
  logic [NCH*RW-1:0] req_data;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dma_insn_frontend #(.AW(AW), .UW(UW), .NCH(NCH), .DEPTH(DEPTH), .IDW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_rd(instr_rd), .instr_rs1(instr_rs1), .instr_rs2(instr_rs2),
    .instr_imm(instr_imm), .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_data(rsp_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data), .xfer_done(xfer_done));

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] mk(input logic [47:0] s, input logic [47:0] d,
      input logic [31:0] len, input logic [31:0] ss, input logic [31:0] ds,
      input logic [31:0] rp, input logic [39:0] u);
    return {s, d, len, ss, ds, rp, u};
  endfunction

  task automatic issue(input logic [3:0] op, input logic [4:0] rd, input logic [31:0] a,
                       input logic [31:0] b, input logic [11:0] im);
    @(negedge clk);
    instr_valid = 1'b1; instr_op = op; instr_rd = rd; instr_rs1 = a; instr_rs2 = b; instr_imm = im;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic pop(input int c);
    req_ready[c] = 1'b1;
    @(negedge clk);
    req_ready[c] = 1'b0;
  endtask

  task automatic done_pulse(input int c);
    @(negedge clk); xfer_done[c] = 1'b1;
    @(negedge clk); xfer_done[c] = 1'b0;
  endtask

  localparam logic [47:0] SRC = 48'hABCD_1000_0000, DST = 48'h1234_2000_0000;
  localparam logic [39:0] USR = 40'h77_DEAD_BEEF;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R9 reset ready", RW'(instr_ready), RW'(1));
    check("R7 reset rsp_valid", RW'(rsp_valid), RW'(0));
    check("R4 reset req_valid", RW'(req_valid), RW'(0));

    for (int i = 0; i < 16; i++) begin
      issue(VECS[i].op, VECS[i].rd, VECS[i].rs1, VECS[i].rs2, VECS[i].imm);
      check($sformatf("R7/R8/R10 vec%0d rsp_valid", i), RW'(rsp_valid), RW'(VECS[i].ev));
      if (VECS[i].ev) begin
        check($sformatf("R7/R8 vec%0d data", i), RW'(rsp_data), RW'(VECS[i].ed));
        check($sformatf("R7 vec%0d rd", i), RW'(rsp_rd), RW'(VECS[i].rd));
      end
    end

    // R9 stall on full ch0; bit0 set (R5 ignored)
    instr_valid = 1'b1; instr_op = 4'd5; instr_rd = 5'd9; instr_rs1 = 32'h100; instr_imm = 12'h001;
    #1 check("R9 stall", RW'(instr_ready), RW'(0));
    @(negedge clk);
    check("R9 still stalled", RW'(instr_ready), RW'(0));
    check("R4 R1 R2 R3 head 2D", req_data[0 +: RW], mk(SRC, DST, 32'h40, 32'h10, 32'h20, 32'h5, USR));
    pop(0);
    check("R9 ready after pop", RW'(instr_ready), RW'(1));
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    check("R9 stalled copy rsp", RW'(rsp_valid), RW'(1));
    check("R7 stalled copy id", RW'(rsp_data), RW'(3));
    check("R6 R11 second 1D", req_data[0 +: RW], mk(SRC, DST, 32'h80, 0, 0, 1, USR));
    pop(0);
    check("R5 R11 third no drop", req_data[0 +: RW], mk(SRC, DST, 32'h100, 0, 0, 1, USR));
    pop(0);
    check("R11 ch0 drained", RW'(req_valid[0]), RW'(0));
    check("R5 ch1 desc", req_data[RW +: RW], mk(SRC, DST, 32'h300, 0, 0, 1, USR));
    pop(1);

    done_pulse(0);
    issue(4'd7, 5'd2, 0, 0, 12'h000);
    check("R8 completed after done", RW'(rsp_data), RW'(1));
    issue(4'd7, 5'd2, 0, 0, 12'h002);
    check("R8 busy partial", RW'(rsp_data), RW'(1));
    done_pulse(0); done_pulse(0);
    issue(4'd7, 5'd2, 0, 0, 12'h002);
    check("R8 idle after retire", RW'(rsp_data), RW'(0));
    issue(4'd7, 5'd2, 0, 0, 12'h003);
    check("R8 not full", RW'(rsp_data), RW'(0));

    // R2 R1 reset values reused by a 2D launch
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    issue(4'd6, 5'd1, 32'h8, 32'h6, 12'h000);
    check("R7 id restarts", RW'(rsp_data), RW'(1));
    check("R2 zero after reset", req_data[RW +: RW], mk(0, 0, 32'h8, 0, 0, 0, 0));
    pop(1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule